// File: doc/BRIEF.md
# Tagged Posted-Store Write Buffer

This block sits between a processor's data port and a slower memory bus and lets stores to buffered memory regions complete in one processor cycle. Each accepted store becomes one or two tagged entries in a 16-deep circular queue. An address-set entry loads a working address. A data entry then writes a byte, halfword or word at that working address. The queue drains in the background and in order. A data entry is presented on a valid/ready write port, and each entry holds the head of the queue for a number of cycles given by the cost that was attached when it was pushed.

The processor stalls in three cases. The first is a store that finds too little free space. The second is a read or instruction fetch to a buffered or cacheable region while any entry is still queued. The third is a store to an unbuffered region, which must wait until the queue is empty and then goes straight to the bus with its own address. Sequential word stores push only a data entry, so a burst continues from the working address. Every word entry advances that address by four when it retires.

Top module: `pstore_buf`

## Requirements
- R1: While reset is high and on the first cycle after it, the queue is empty, the working address is 0, `cpu_stall` is low and `bus_valid` is low.
- R2: Store size codes are 0 = byte, 1 = halfword, 2 = word (3 is treated as word) and are driven on `bus_size` with the same encoding. Byte data is replicated on all four lanes and halfword data on both halves. The strobe is `4'b0001 << addr[1:0]` for a byte, `4'b1100` or `4'b0011` for a halfword (picked by addr[1]), and `4'b1111` for a word.
- R3: A buffered store that is not a sequential word pushes an address-set entry with cost 1 and then a data entry with cost `cpu_st_cost`. Its data is written at `cpu_st_addr`. When there is room, the store is accepted in the cycle it is presented, with no stall.
- R4: A buffered store with `cpu_st_seq` high and word size pushes only a data entry, which is written at the working address. Retiring a word entry adds 4 to the working address. Byte and halfword entries leave it unchanged, and an address-set entry replaces it.
- R5: Entries complete back to back. An address-set entry holds the head for its cost in cycles. A data entry holds the head for its cost in cycles, counted from the cycle the bus accepts it. A cost of 0 counts as 1.
- R6: The queue holds 16 entries. A store that needs more free entries than remain, counting an entry that retires in the same cycle, is stalled. It is accepted in the cycle in which the head retires and frees enough room.
- R7: A read or fetch with `cpu_rd_buffered` high stalls the processor until the queue is empty. With `cpu_rd_buffered` low, a read causes no stall even while entries are queued.
- R8: A store with `cpu_st_buffered` low waits (stalled) until the queue is empty. It then drives the bus directly with its own address, is stalled until `bus_ready`, and does not change the working address.
- R9: Bus writes appear in the order the stores were accepted. While `bus_valid` is high and `bus_ready` low, the write stays valid with the same address and strobes.
- R10: Whenever the queue becomes empty, both queue pointers return to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_st_valid | input | 1 | Store request, held until not stalled |
| cpu_st_buffered | input | 1 | Target region is cacheable or write-buffered |
| cpu_st_seq | input | 1 | Sequential word store (burst continuation) |
| cpu_st_size | input | 2 | 0 byte, 1 halfword, 2 word |
| cpu_st_addr | input | 32 | Store address |
| cpu_st_data | input | 32 | Store data, right-aligned |
| cpu_st_cost | input | 8 | Write cost of the target region in cycles |
| cpu_rd_valid | input | 1 | Data read or instruction fetch request |
| cpu_rd_buffered | input | 1 | Read target is cacheable or write-buffered |
| cpu_stall | output | 1 | Processor must hold its request |
| bus_valid | output | 1 | Bus write request |
| bus_ready | input | 1 | Bus accepts the write |
| bus_addr | output | 32 | Bus write address |
| bus_data | output | 32 | Lane-replicated write data |
| bus_size | output | 2 | Access size, same encoding as cpu_st_size |
| bus_strb | output | 4 | Byte-lane write strobes |

## Verification
The case that matters is a retire and a push in the same cycle. The queue is filled to 16 entries with `bus_ready` held low, and one more sequential store is presented while the bench confirms the stall. `bus_ready` is then raised, so the head word is accepted and retires at cost 1. The bench checks that the stall drops in that same cycle and that the seventeenth store lands at the next incremented address. The second overlap is a buffered read or an unbuffered store meeting a draining queue. Its stall length is compared with the summed costs of the entries still queued.

// File: rtl/psb_pkg.sv
package psb_pkg;

    localparam int WORD_W = 32;
    localparam int COST_W = 8;
    localparam int STRB_W = WORD_W / 8;

    typedef enum logic [1:0] {
        TAG_BYTE = 2'd0,
        TAG_HALF = 2'd1,
        TAG_WORD = 2'd2,
        TAG_ADDR = 2'd3
    } tag_e;

    typedef struct packed {
        tag_e              tag;
        logic [WORD_W-1:0] payload;
        logic [COST_W-1:0] cost;
    } entry_t;

    // size code 3 has no data meaning: fold it onto word
    function automatic tag_e size_to_tag(input logic [1:0] sz);
        case (sz)
            2'd0:    return TAG_BYTE;
            2'd1:    return TAG_HALF;
            default: return TAG_WORD;
        endcase
    endfunction

    function automatic logic [STRB_W-1:0] lane_strb(input tag_e t, input logic [1:0] lo);
        case (t)
            TAG_BYTE: return STRB_W'(1) << lo;
            TAG_HALF: return lo[1] ? STRB_W'(4'b1100) : STRB_W'(4'b0011);
            default:  return '1;
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] lane_data(input tag_e t, input logic [WORD_W-1:0] d);
        case (t)
            TAG_BYTE: return {4{d[7:0]}};
            TAG_HALF: return {2{d[15:0]}};
            default:  return d;
        endcase
    endfunction

endpackage

// File: rtl/psb_fifo.sv
module psb_fifo
    import psb_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       push_cnt,
    input  entry_t           push_a,
    input  entry_t           push_b,
    input  logic             pop,
    output entry_t           head,
    output logic [CNT_W-1:0] count
);

    entry_t           mem [DEPTH];
    logic [PTR_W-1:0] rd_ptr, wr_ptr, wr_nxt;
    logic [CNT_W-1:0] cnt_next;

    assign wr_nxt   = wr_ptr + PTR_W'(1);
    assign cnt_next = count - CNT_W'(pop) + CNT_W'(push_cnt);
    assign head     = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            count <= cnt_next;
            if (cnt_next == '0) begin
                rd_ptr <= '0;
                wr_ptr <= '0;
            end else begin
                rd_ptr <= rd_ptr + PTR_W'(pop);
                wr_ptr <= wr_ptr + PTR_W'(push_cnt);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (push_cnt != 2'd0) mem[wr_ptr] <= push_a;
        if (push_cnt == 2'd2) mem[wr_nxt] <= push_b;
    end

    // R10
    ptr_clear_chk: assert property (@(posedge clk) disable iff (rst)
        count == '0 |-> (rd_ptr == '0 && wr_ptr == '0));

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));

endmodule

// File: rtl/psb_drain.sv
module psb_drain
    import psb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  entry_t            head,
    input  logic              nonempty,
    input  logic              bus_ready,
    output logic              pop,
    output logic              q_valid,
    output logic [WORD_W-1:0] q_addr,
    output logic [WORD_W-1:0] q_data,
    output logic [1:0]        q_size,
    output logic [STRB_W-1:0] q_strb
);

    logic              busy;
    logic [COST_W-1:0] remain, cost_eff;
    logic [WORD_W-1:0] wa;
    logic              is_data, can_start, start;

    assign is_data   = head.tag != TAG_ADDR;
    assign can_start = nonempty && !busy;
    assign q_valid   = can_start && is_data;
    assign start     = can_start && (!is_data || bus_ready);
    assign cost_eff  = (head.cost == '0) ? COST_W'(1) : head.cost;
    assign pop       = (start && cost_eff == COST_W'(1)) || (busy && remain == COST_W'(1));

    assign q_addr = wa;
    assign q_data = lane_data(head.tag, head.payload);
    assign q_size = head.tag;
    assign q_strb = lane_strb(head.tag, wa[1:0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            remain <= '0;
            wa     <= '0;
        end else begin
            if (start && cost_eff != COST_W'(1)) begin
                busy   <= 1'b1;
                remain <= cost_eff - COST_W'(1);
            end else if (busy) begin
                if (remain == COST_W'(1)) busy <= 1'b0;
                remain <= remain - COST_W'(1);
            end
            if (pop) begin
                case (head.tag)
                    TAG_ADDR: wa <= head.payload;
                    TAG_WORD: wa <= wa + WORD_W'(4);
                    default:  wa <= wa;
                endcase
            end
        end
    end

    // R4
    wa_step_chk: assert property (@(posedge clk) disable iff (rst)
        (pop && head.tag == TAG_WORD) |=> wa == $past(wa) + WORD_W'(4));

    // R5
    start_on_accept_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(head.tag == TAG_ADDR || bus_ready));

endmodule

// File: rtl/pstore_buf.sv
module pstore_buf
    import psb_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cpu_st_valid,
    input  logic        cpu_st_buffered,
    input  logic        cpu_st_seq,
    input  logic [1:0]  cpu_st_size,
    input  logic [31:0] cpu_st_addr,
    input  logic [31:0] cpu_st_data,
    input  logic [7:0]  cpu_st_cost,
    input  logic        cpu_rd_valid,
    input  logic        cpu_rd_buffered,
    output logic        cpu_stall,
    output logic        bus_valid,
    input  logic        bus_ready,
    output logic [31:0] bus_addr,
    output logic [31:0] bus_data,
    output logic [1:0]  bus_size,
    output logic [3:0]  bus_strb
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    entry_t            head, ent_a, ent_b, data_ent, addr_ent;
    logic [CNT_W-1:0]  q_count;
    logic [CNT_W:0]    fill_after;
    logic              q_pop, q_empty, room, accept, buf_st, byp, seq_word;
    logic [1:0]        need, push_cnt;
    tag_e              st_tag;
    logic              q_valid;
    logic [WORD_W-1:0] q_addr, q_data;
    logic [1:0]        q_size;
    logic [STRB_W-1:0] q_strb;

    assign st_tag   = size_to_tag(cpu_st_size);
    assign seq_word = cpu_st_seq && st_tag == TAG_WORD;
    assign need     = seq_word ? 2'd1 : 2'd2;
    assign q_empty  = q_count == '0;

    assign fill_after = {1'b0, q_count} - (CNT_W + 1)'(q_pop) + (CNT_W + 1)'(need);
    assign room       = fill_after <= (CNT_W + 1)'(DEPTH);

    assign buf_st   = cpu_st_valid && cpu_st_buffered;
    assign byp      = cpu_st_valid && !cpu_st_buffered;
    assign accept   = buf_st && room;
    assign push_cnt = accept ? need : 2'd0;

    assign data_ent = '{tag: st_tag, payload: cpu_st_data, cost: cpu_st_cost};
    assign addr_ent = '{tag: TAG_ADDR, payload: cpu_st_addr, cost: COST_W'(1)};
    assign ent_a    = seq_word ? data_ent : addr_ent;
    assign ent_b    = data_ent;

    psb_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk      (clk),
        .rst      (rst),
        .push_cnt (push_cnt),
        .push_a   (ent_a),
        .push_b   (ent_b),
        .pop      (q_pop),
        .head     (head),
        .count    (q_count)
    );

    psb_drain u_drain (
        .clk       (clk),
        .rst       (rst),
        .head      (head),
        .nonempty  (!q_empty),
        .bus_ready (bus_ready),
        .pop       (q_pop),
        .q_valid   (q_valid),
        .q_addr    (q_addr),
        .q_data    (q_data),
        .q_size    (q_size),
        .q_strb    (q_strb)
    );

    // unbuffered stores own the bus only when nothing is queued ahead of them
    always_comb begin
        if (q_empty) begin
            bus_valid = byp;
            bus_addr  = cpu_st_addr;
            bus_data  = lane_data(st_tag, cpu_st_data);
            bus_size  = st_tag;
            bus_strb  = lane_strb(st_tag, cpu_st_addr[1:0]);
        end else begin
            bus_valid = q_valid;
            bus_addr  = q_addr;
            bus_data  = q_data;
            bus_size  = q_size;
            bus_strb  = q_strb;
        end
    end

    assign cpu_stall = (buf_st && !room)
                     || (byp && (!q_empty || !bus_ready))
                     || (cpu_rd_valid && cpu_rd_buffered && !q_empty);

    // R9
    bus_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr) && $stable(bus_strb)));

    // R7
    read_drain_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_rd_valid && cpu_rd_buffered && !cpu_stall) |-> q_count == '0);

endmodule

// File: tb/pstore_buf_test.sv
module pstore_buf_test;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        cpu_st_valid, cpu_st_buffered, cpu_st_seq;
    logic [1:0]  cpu_st_size;
    logic [31:0] cpu_st_addr, cpu_st_data;
    logic [7:0]  cpu_st_cost;
    logic        cpu_rd_valid, cpu_rd_buffered;
    logic        cpu_stall;
    logic        bus_valid, bus_ready;
    logic [31:0] bus_addr, bus_data;
    logic [1:0]  bus_size;
    logic [3:0]  bus_strb;

    typedef struct packed {
        logic [31:0] a;
        logic [31:0] d;
        logic [3:0]  s;
        logic [1:0]  z;
    } exp_t;

    exp_t        exp_q[$];
    logic [31:0] m_wa;
    int          n_tests = 0;
    int          n_fail  = 0;
    bit          done    = 0;

    pstore_buf #(.DEPTH(16)) uut (
        .clk(clk), .rst(rst),
        .cpu_st_valid(cpu_st_valid), .cpu_st_buffered(cpu_st_buffered),
        .cpu_st_seq(cpu_st_seq), .cpu_st_size(cpu_st_size),
        .cpu_st_addr(cpu_st_addr), .cpu_st_data(cpu_st_data),
        .cpu_st_cost(cpu_st_cost),
        .cpu_rd_valid(cpu_rd_valid), .cpu_rd_buffered(cpu_rd_buffered),
        .cpu_stall(cpu_stall),
        .bus_valid(bus_valid), .bus_ready(bus_ready),
        .bus_addr(bus_addr), .bus_data(bus_data),
        .bus_size(bus_size), .bus_strb(bus_strb)
    );

    always #(CLK_P / 2) clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // model of the expected bus write for one store (R2, R3, R4, R8)
    task automatic expect_store(input logic [31:0] a, input logic [31:0] d, input logic [1:0] sz,
                                input logic seq, input logic bf);
        exp_t e;
        logic [1:0] t;
        t = (sz == 2'd3) ? 2'd2 : sz;
        if (bf && seq && t == 2'd2) begin
            e.a  = m_wa;
            m_wa = m_wa + 32'd4;
        end else begin
            e.a = a;
            if (bf) m_wa = (t == 2'd2) ? a + 32'd4 : a;
        end
        case (t)
            2'd0:    begin e.d = {4{d[7:0]}};  e.s = 4'b0001 << e.a[1:0]; end
            2'd1:    begin e.d = {2{d[15:0]}}; e.s = e.a[1] ? 4'b1100 : 4'b0011; end
            default: begin e.d = d;            e.s = 4'b1111; end
        endcase
        e.z = t;
        exp_q.push_back(e);
    endtask

    // called at posedge+1; returns at posedge+1 after acceptance
    task automatic do_store(input logic [31:0] a, input logic [31:0] d, input logic [1:0] sz,
                            input logic seq, input logic bf, input logic [7:0] cost, output int waited);
        expect_store(a, d, sz, seq, bf);
        cpu_st_valid = 1; cpu_st_addr = a; cpu_st_data = d; cpu_st_size = sz;
        cpu_st_seq = seq; cpu_st_buffered = bf; cpu_st_cost = cost;
        waited = 0;
        forever begin
            @(negedge clk);
            if (!cpu_stall) break;
            waited++;
        end
        @(posedge clk); #1;
        cpu_st_valid = 0;
    endtask

    task automatic drain_read(output int n);
        cpu_rd_valid = 1; cpu_rd_buffered = 1;
        n = 0;
        forever begin
            @(negedge clk);
            if (!cpu_stall) break;
            n++;
        end
        @(posedge clk); #1;
        cpu_rd_valid = 0;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && bus_valid && bus_ready) begin
            n_tests++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R9 unexpected bus write: actual addr %h expected none", bus_addr);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (bus_addr !== e.a || bus_data !== e.d || bus_strb !== e.s || bus_size !== e.z) begin
                    n_fail++;
                    $display("FAIL R2/R9 bus write: actual a=%h d=%h s=%b z=%0d expected a=%h d=%h s=%b z=%0d",
                             bus_addr, bus_data, bus_strb, bus_size, e.a, e.d, e.s, e.z);
                end
            end
        end
    end

    initial begin
        #(CLK_P * 50000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int w, n;
        rst = 1; cpu_st_valid = 0; cpu_st_buffered = 0; cpu_st_seq = 0; cpu_st_size = 0;
        cpu_st_addr = 0; cpu_st_data = 0; cpu_st_cost = 0; cpu_rd_valid = 0;
        cpu_rd_buffered = 0; bus_ready = 1; m_wa = 0;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        // R1 reset state
        check(cpu_stall == 0, "R1 stall after reset", 32'(cpu_stall), 0);
        check(bus_valid == 0, "R1 bus_valid after reset", 32'(bus_valid), 0);
        @(posedge clk); #1;

        // R3, R5: single word, cost 3 -> 1 + 3 stalled read cycles
        do_store(32'h1000, 32'hDEADBEEF, 2'd2, 0, 1, 8'd3, w);
        check(w == 0, "R3 buffered store accepted in one cycle", w, 0);
        drain_read(n);
        check(n == 4, "R5 drain length single store", n, 4);

        // R5: two stores back to back, then read: 2 + 1 + 5 remaining
        do_store(32'h2000, 32'h01234567, 2'd2, 0, 1, 8'd2, w);
        do_store(32'h2041, 32'h000000A5, 2'd0, 0, 1, 8'd5, w);
        check(w == 0, "R3 second store accepted in one cycle", w, 0);
        drain_read(n);
        check(n == 8, "R5 back-to-back drain length", n, 8);

        // R7: unbuffered read does not stall, buffered one waits
        do_store(32'h3000, 32'hCAFEF00D, 2'd2, 0, 1, 8'd6, w);
        cpu_rd_valid = 1; cpu_rd_buffered = 0;
        @(negedge clk);
        check(cpu_stall == 0, "R7 unbuffered read no stall", 32'(cpu_stall), 0);
        @(posedge clk); #1;
        drain_read(n);
        check(n == 6, "R7 buffered read waits for drain", n, 6);

        // R4, R2: half then sequential words continue from unchanged address
        do_store(32'h0200, 32'hABCD1234, 2'd1, 0, 1, 8'd2, w);
        do_store(32'h0, 32'h11112222, 2'd2, 1, 1, 8'd1, w);
        do_store(32'h0, 32'h33334444, 2'd2, 1, 1, 8'd0, w);
        do_store(32'h02F3, 32'h0000005A, 2'd0, 0, 1, 8'd1, w);
        do_store(32'h0302, 32'h0000BEEF, 2'd1, 0, 1, 8'd1, w);
        drain_read(n);
        check(exp_q.size() == 0, "R4 all writes seen after drain", exp_q.size(), 0);

        // R6: fill 16 entries with the bus blocked
        bus_ready = 0;
        do_store(32'h4000, 32'h40000000, 2'd2, 0, 1, 8'd1, w);
        for (int i = 1; i < 16; i++) begin
            do_store(32'h0, 32'h40000000 + i, 2'd2, 1, 1, 8'd1, w);
            check(w == 0, "R6 store accepted below capacity", w, 0);
        end
        expect_store(32'h0, 32'h40000010, 2'd2, 1, 1);
        cpu_st_valid = 1; cpu_st_seq = 1; cpu_st_size = 2'd2; cpu_st_buffered = 1;
        cpu_st_data = 32'h40000010; cpu_st_cost = 8'd1;
        @(negedge clk);
        check(cpu_stall == 1, "R6 stall on full queue", 32'(cpu_stall), 1);
        @(negedge clk);
        check(cpu_stall == 1, "R6 stall held while bus blocked", 32'(cpu_stall), 1);
        @(posedge clk); #1;
        bus_ready = 1;
        #1;
        check(cpu_stall == 0, "R6 accepted in the retiring cycle", 32'(cpu_stall), 0);
        @(posedge clk); #1;
        cpu_st_valid = 0;
        drain_read(n);
        check(n == 16, "R5 full queue drain length", n, 16);

        // R8: bypass when empty, then bypass behind queued work
        do_store(32'h5000, 32'h55556666, 2'd2, 0, 0, 8'd9, w);
        check(w == 0, "R8 bypass with empty queue", w, 0);
        do_store(32'h6000, 32'h66667777, 2'd2, 0, 1, 8'd4, w);
        do_store(32'h7001, 32'h00000077, 2'd0, 0, 0, 8'd1, w);
        check(w == 5, "R8 bypass waits for queue drain", w, 5);
        do_store(32'h0, 32'h88889999, 2'd2, 1, 1, 8'd1, w);
        drain_read(n);

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R9 every expected write observed", exp_q.size(), 0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule